// File: doc/BRIEF.md
# Vertical Sync Confidence Counter

This block keeps a running score of how dependably the vertical sync pulse of incoming video lands inside the search window that the vertical controller currently uses. Once per field the controller sends either a hit strobe (pulse found in the window) or a miss strobe (pulse absent or outside it). The block holds a saturating 4-bit score, and from that score it derives a three-level confidence grade. The vertical controller uses the grade to choose between free-running generation, a narrow search window and a wide search window. A single status bit reports whether the grade is at the top level.

The score rises slowly and falls quickly. A miss costs two points at the top grade. At the middle grade a miss drops the score straight to the top of the lowest grade, so the controller never spends many fields creeping down toward zero before it opens its wide window. A lone good pulse that follows bad ones at the middle or top grade is scored as bad, so a source that alternates good and bad fields cannot hold a high grade. When horizontal lock is lost, the score is cleared at once. A force control caps the score inside the lowest grade, which keeps the wide window in use.

Top module: `nc_norm_counter`

## Requirements
- R1: After synchronous reset the score is 0, the grade is 2'b00 (no-norm) and the status bit is 0.
- R2: A hit strobe with no miss, no lock loss and no force raises the score by 1 on the next clock edge, or by 0 when the score is already 15.
- R3: The grade output is 2'b00 for a score of 0 to 5, 2'b01 (near-norm) for 6 to 11 and 2'b10 (norm) for 12 to 15. The status bit is 1 exactly when the grade is 2'b10.
- R4: An effective miss while the grade is norm lowers the score by 2.
- R5: An effective miss while the grade is near-norm sets the score to 5.
- R6: An effective miss while the grade is no-norm lowers the score by 1, saturating at 0.
- R7: Any miss sets a bad-pulse memory, and the next hit clears it. A hit that arrives while the memory is set and the grade is near-norm or norm is scored as a miss. Any later hit counts normally.
- R8: A lock-loss input sets the score to 0 on the next edge and clears the bad-pulse memory. It overrides every other input.
- R9: While the force input is high, each updated score is the smaller of its normal next value and 5. The score therefore stays in the no-norm grade, and misses still lower it.
- R10: When a hit and a miss arrive in the same cycle, the cycle is scored as a miss.
- R11: With no strobe, no lock loss and no force, the score holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Per-field strobe: sync pulse found inside the window |
| miss_i | input | 1 | Per-field strobe: sync pulse missing or outside the window |
| lock_lost_i | input | 1 | Horizontal lock lost; clears the score |
| force_wide_i | input | 1 | Holds the score within the no-norm grade |
| count_o | output | 4 | Current confidence score |
| level_o | output | 2 | Grade: 00 no-norm, 01 near-norm, 10 norm |
| norm_o | output | 1 | Status: 1 when the grade is norm |

## Verification
The assertions check on every cycle that a clean hit at the lowest grade adds exactly one point, that lock loss clears the score, that force keeps the score at or below 5, that an idle cycle leaves the score unchanged, and that a miss at the middle grade lands on 5. Only the bench scenarios show the sequence-dependent behaviour: a good pulse after a bad one being scored as a miss, and then the following good pulse counting again. The bench also covers the saturation points at 0 and 15, the exact grade boundaries at 5/6 and 11/12, and a hit and a miss arriving together.

// File: rtl/nc_pkg.sv
package nc_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_NEAR = 2'b01,
        LVL_NORM = 2'b10
    } nc_level_e;

    typedef struct packed {
        logic up;
        logic down;
    } nc_evt_t;

    function automatic nc_level_e level_of(input int unsigned cnt,
                                           input int unsigned near_lo,
                                           input int unsigned norm_lo);
        if (cnt >= norm_lo)      return LVL_NORM;
        else if (cnt >= near_lo) return LVL_NEAR;
        else                     return LVL_NONE;
    endfunction

endpackage

// File: rtl/nc_event_filter.sv
module nc_event_filter
    import nc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit_i,
    input  logic      miss_i,
    input  logic      lock_lost_i,
    input  nc_level_e lvl_i,
    output nc_evt_t   evt_o
);
    logic bad_q;

    always_comb begin
        evt_o = '0;
        if (miss_i) begin
            evt_o.down = 1'b1;
        end else if (hit_i) begin
            if (bad_q && lvl_i != LVL_NONE) evt_o.down = 1'b1;
            else                            evt_o.up   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || lock_lost_i) bad_q <= 1'b0;
        else if (miss_i)        bad_q <= 1'b1;
        else if (hit_i)         bad_q <= 1'b0;
    end

    // R7: an effective up event never comes from a hit at a high grade while memory is set
    p_bad_blocks_up_r7: assert property (@(posedge clk) disable iff (rst)
        (bad_q && lvl_i != LVL_NONE) |-> !evt_o.up);

endmodule

// File: rtl/nc_step_calc.sv
module nc_step_calc
    import nc_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int NEAR_LO   = 6,
    parameter int NORM_DROP = 2
) (
    input  logic [CNT_W-1:0] count_i,
    input  nc_level_e        lvl_i,
    input  nc_evt_t          evt_i,
    input  logic             lock_lost_i,
    input  logic             force_wide_i,
    output logic [CNT_W-1:0] count_next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LOW_TOP = CNT_W'(NEAR_LO - 1);
    localparam logic [CNT_W-1:0] DROP    = CNT_W'(NORM_DROP);

    logic [CNT_W-1:0] stepped;

    always_comb begin
        stepped = count_i;
        if (evt_i.down) begin
            unique case (lvl_i)
                LVL_NORM: stepped = (count_i >= DROP) ? count_i - DROP : '0;
                LVL_NEAR: stepped = LOW_TOP;
                default:  stepped = (count_i != '0) ? count_i - 1'b1 : '0;
            endcase
        end else if (evt_i.up) begin
            stepped = (count_i != CNT_MAX) ? count_i + 1'b1 : count_i;
        end

        count_next_o = stepped;
        if (force_wide_i && stepped > LOW_TOP) count_next_o = LOW_TOP;
        if (lock_lost_i) count_next_o = '0;
    end

endmodule

// File: rtl/nc_level_map.sv
module nc_level_map
    import nc_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int NEAR_LO = 6,
    parameter int NORM_LO = 12
) (
    input  logic [CNT_W-1:0] count_i,
    output nc_level_e        lvl_o,
    output logic             norm_o
);
    always_comb begin
        lvl_o  = level_of(int'(count_i), NEAR_LO, NORM_LO);
        norm_o = (lvl_o == LVL_NORM);
    end

endmodule

// File: rtl/nc_norm_counter.sv
module nc_norm_counter
    import nc_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int NEAR_LO   = 6,
    parameter int NORM_LO   = 12,
    parameter int NORM_DROP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             miss_i,
    input  logic             lock_lost_i,
    input  logic             force_wide_i,
    output logic [CNT_W-1:0] count_o,
    output logic [1:0]       level_o,
    output logic             norm_o
);
    localparam logic [CNT_W-1:0] LOW_TOP = CNT_W'(NEAR_LO - 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_next;
    nc_level_e        lvl;
    nc_evt_t          evt;

    nc_level_map #(.CNT_W(CNT_W), .NEAR_LO(NEAR_LO), .NORM_LO(NORM_LO)) u_map (
        .count_i (count_q),
        .lvl_o   (lvl),
        .norm_o  (norm_o)
    );

    nc_event_filter u_filter (
        .clk         (clk),
        .rst         (rst),
        .hit_i       (hit_i),
        .miss_i      (miss_i),
        .lock_lost_i (lock_lost_i),
        .lvl_i       (lvl),
        .evt_o       (evt)
    );

    nc_step_calc #(.CNT_W(CNT_W), .NEAR_LO(NEAR_LO), .NORM_DROP(NORM_DROP)) u_step (
        .count_i      (count_q),
        .lvl_i        (lvl),
        .evt_i        (evt),
        .lock_lost_i  (lock_lost_i),
        .force_wide_i (force_wide_i),
        .count_next_o (count_next)
    );

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_next;
    end

    assign count_o = count_q;
    assign level_o = lvl;

    p_hit_up_r2: assert property (@(posedge clk) disable iff (rst)
        (hit_i && !miss_i && !lock_lost_i && !force_wide_i && lvl == LVL_NONE)
        |=> count_q == $past(count_q) + 1'b1);

    p_near_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (miss_i && !lock_lost_i && !force_wide_i && lvl == LVL_NEAR)
        |=> count_q == LOW_TOP);

    p_lock_clear_r8: assert property (@(posedge clk) disable iff (rst)
        lock_lost_i |=> count_q == '0);

    p_force_cap_r9: assert property (@(posedge clk) disable iff (rst)
        force_wide_i |=> count_q <= LOW_TOP);

    p_tie_miss_r10: assert property (@(posedge clk) disable iff (rst)
        (hit_i && miss_i && !lock_lost_i && !force_wide_i && lvl == LVL_NONE && count_q != '0)
        |=> count_q == $past(count_q) - 1'b1);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!hit_i && !miss_i && !lock_lost_i && !force_wide_i) |=> $stable(count_q));

endmodule

// File: tb/nc_norm_counter_bench.sv
module nc_norm_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit = 1'b0;
    logic       miss = 1'b0;
    logic       lock_lost = 1'b0;
    logic       force_wide = 1'b0;
    logic [3:0] count;
    logic [1:0] level;
    logic       norm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    nc_norm_counter u_nc_norm_counter (
        .clk          (clk),
        .rst          (rst),
        .hit_i        (hit),
        .miss_i       (miss),
        .lock_lost_i  (lock_lost),
        .force_wide_i (force_wide),
        .count_o      (count),
        .level_o      (level),
        .norm_o       (norm)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hit = 0; miss = 0; lock_lost = 0; force_wide = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one field event applied across exactly one rising edge
    task automatic pulse(input logic h, input logic m, input logic l);
        hit = h; miss = m; lock_lost = l;
        @(negedge clk);
        hit = 0; miss = 0; lock_lost = 0;
    endtask

    task automatic go_to(input int n);
        do_reset();
        for (int i = 0; i < n; i++) pulse(1, 0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count, 0);
        check("R1 level", level, 0);
        check("R1 norm", norm, 0);
    endtask

    task automatic t_climb();
        do_reset();
        for (int i = 1; i <= 16; i++) begin
            pulse(1, 0, 0);
            check("R2 count", count, (i > 15) ? 15 : i);
            if (i == 5)  check("R3 level at 5", level, 0);
            if (i == 6)  check("R3 level at 6", level, 1);
            if (i == 11) check("R3 level at 11", level, 1);
            if (i == 11) check("R3 norm at 11", norm, 0);
            if (i == 12) check("R3 level at 12", level, 2);
            if (i == 12) check("R3 norm at 12", norm, 1);
        end
    endtask

    task automatic t_norm_miss();
        go_to(15);
        pulse(0, 1, 0);
        check("R4 15 minus 2", count, 13);
        go_to(12);
        pulse(0, 1, 0);
        check("R4 12 minus 2", count, 10);
        check("R4/R3 level after drop", level, 1);
    endtask

    task automatic t_near_miss();
        go_to(9);
        pulse(0, 1, 0);
        check("R5 near miss", count, 5);
        check("R5 level", level, 0);
    endtask

    task automatic t_low_miss();
        go_to(2);
        pulse(0, 1, 0);
        check("R6 2 to 1", count, 1);
        pulse(0, 1, 0);
        check("R6 1 to 0", count, 0);
        pulse(0, 1, 0);
        check("R6 floor", count, 0);
    endtask

    task automatic t_good_after_bad();
        go_to(15);
        pulse(0, 1, 0);
        check("R7 setup", count, 13);
        pulse(1, 0, 0);
        check("R7 first good scored bad", count, 11);
        pulse(1, 0, 0);
        check("R7 second good counts", count, 12);
        go_to(3);
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        check("R7 low grade hit counts", count, 3);
    endtask

    task automatic t_lock_lost();
        go_to(14);
        pulse(1, 0, 1);
        check("R8 clear", count, 0);
        check("R8 level", level, 0);
        go_to(7);
        pulse(0, 1, 0);
        pulse(0, 0, 1);
        for (int i = 0; i < 6; i++) pulse(1, 0, 0);
        pulse(1, 0, 0);
        check("R8 memory cleared", count, 7);
    endtask

    task automatic t_force();
        do_reset();
        force_wide = 1'b1;
        for (int i = 0; i < 8; i++) pulse(1, 0, 0);
        check("R9 cap on hits", count, 5);
        pulse(0, 1, 0);
        check("R9 miss still lowers", count, 4);
        go_to(14);
        force_wide = 1'b1;
        @(negedge clk);
        check("R9 clamp when idle", count, 5);
        force_wide = 1'b0;
    endtask

    task automatic t_tie();
        go_to(13);
        pulse(1, 1, 0);
        check("R10 tie is miss", count, 11);
        go_to(3);
        pulse(1, 1, 0);
        check("R10 tie at low grade", count, 2);
    endtask

    task automatic t_idle();
        go_to(7);
        repeat (3) @(negedge clk);
        check("R11 hold", count, 7);
        check("R11 level hold", level, 1);
    endtask

    initial begin
        t_reset();
        t_climb();
        t_norm_miss();
        t_near_miss();
        t_low_miss();
        t_good_after_bad();
        t_lock_lost();
        t_force();
        t_tie();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule